// File: doc/BRIEF.md
# Configurable Up/Down Event Timer with PWM

This block is a 10-bit timer/counter. At run time its active length can be cut to 8, 6 or 4 bits. It counts up or down, one step per qualifying tick. A tick comes from one of eight single-cycle enable inputs, such as prescaler taps or debounced event pins, and is qualified by a run control. Every input is sampled on the one system clock. A load strobe copies a load value straight into the counter. The same load value is also the reload value for down counting.

A compare value is matched against the counter after each step. The match can use all ten bits or only the active bits. The block gives one interrupt pulse when a step meets the compare value and another when a step reaches zero. A PWM output goes high when the counter reloads and low on a compare match.

An optional mode treats the least significant bit as don't-care. In that mode the counter moves in steps of two with bit 0 held at 0, and the compare ignores bit 0. This makes the timer one bit shorter. All controls are plain level or strobe pins. No data stream crosses the edge of the block, so it has no handshake.

Top module: `updn_pwm_timer`

## Requirements
- R1: `len_sel` picks the active length: 0 gives 10 bits, 1 gives 8, 2 gives 6 and 3 gives 4. The bits of `count` above the active length always read 0.
- R2: When counting up (`count_up`=1), a tick at the top value of the active length wraps the count to 0. The top value is all ones, or all ones with bit 0 clear when `skip_lsb`=1.
- R3: When counting down, a tick at 0 reloads the count from `load_val` masked to the active bits. Any other tick decrements the count by one step.
- R4: `load_stb` sets `count` to `load_val` masked to the active bits on the next cycle. It takes priority over a tick in the same cycle and raises no interrupt.
- R5: A tick is `src_tick[src_sel]` while `run`=1. The unselected sources have no effect, and so does the selected source while `run`=0.
- R6: When `cmp_full`=1, the compare uses all 10 bits. When it is 0, the compare uses only the active bits, so upper bits of `cmp_val` are ignored.
- R7: When `skip_lsb`=1, the step is 2, bit 0 of `count` stays 0, and bit 0 of `cmp_val` is ignored.
- R8: `irq_zero` is a one-cycle pulse, shown together with the new count, after a tick that steps the counter to 0. This includes the wrap to 0 when counting up. A reload never raises it.
- R9: `irq_cmp` is a one-cycle pulse, shown together with the new count, after a tick whose new count equals the masked compare value.
- R10: When `pwm_en`=1, `pwm_out` goes high after a reload (the up wrap or the down reload) and low after a compare match. When the masked compare value is 0, `pwm_out` stays low. When `pwm_en`=0, `pwm_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enables counting on ticks |
| src_tick | input | 8 | Single-cycle tick enables, one per clock source |
| src_sel | input | 3 | Index of the source that drives the counter |
| count_up | input | 1 | 1 counts up, 0 counts down |
| len_sel | input | 2 | Active length: 0=10, 1=8, 2=6, 3=4 bits |
| skip_lsb | input | 1 | Treats bit 0 as don't-care (step of 2) |
| cmp_full | input | 1 | 1 compares all 10 bits, 0 only the active bits |
| load_val | input | 10 | Parallel load and reload value |
| load_stb | input | 1 | Loads `load_val` into the counter |
| cmp_val | input | 10 | Compare value |
| pwm_en | input | 1 | Enables the PWM output |
| count | output | 10 | Current count, masked to the active bits |
| irq_cmp | output | 1 | Compare-match pulse |
| irq_zero | output | 1 | Reached-zero pulse |
| pwm_out | output | 1 | PWM output |

## Verification
The counter runs through a stepped scenario:
- A 4-bit up count crossing the wrap, which separates the wrap-to-zero rule from a plain increment.
- A down count through zero into a reload, which shows that reaching 0 and reloading happen on two separate ticks.
- A 6-bit run with bit 0 skipped, which exposes the step of two and the masked load.

The same loaded value is then stepped with full-width and with limited compare. This shows whether the upper compare bits are ignored. Directed cases cover the following:
- A load and a tick in the same cycle, to check load priority.
- A tick while `run` is low.
- A compare value of zero, where match and wrap land on the same tick.
- PWM gating.

// File: rtl/updn_tmr_pkg.sv
package updn_tmr_pkg;
  localparam int TMR_W   = 10;
  localparam int TMR_SRC = 8;

  typedef enum logic [1:0] {
    LEN_FULL = 2'd0,
    LEN_M2   = 2'd1,
    LEN_M4   = 2'd2,
    LEN_M6   = 2'd3
  } len_e;

  // mask of active bits: full width shortened by two bits per len step
  function automatic logic [TMR_W-1:0] len_mask(input logic [1:0] len);
    logic [TMR_W-1:0] m;
    m = {TMR_W{1'b1}} >> (2 * int'(len));
    return m;
  endfunction
endpackage

// File: rtl/updn_tmr_tick_sel.sv
module updn_tmr_tick_sel #(
  parameter int NSRC  = updn_tmr_pkg::TMR_SRC,
  localparam int SEL_W = $clog2(NSRC)
) (
  input  logic             run,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SEL_W-1:0] src_sel,
  output logic             tick
);
  logic [NSRC-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_src
      assign hit[gi] = src_tick[gi] && (src_sel == SEL_W'(gi));
    end
  endgenerate

  assign tick = run && (|hit);
endmodule

// File: rtl/updn_tmr_core.sv
module updn_tmr_core #(
  parameter int W = updn_tmr_pkg::TMR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic         up,
  input  logic [W-1:0] act_mask,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic [W-1:0] nxt,
  output logic         step_ev,
  output logic         reload_ev,
  output logic         zero_ev
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cur;
  logic [W-1:0] step;
  logic         at_top;
  logic         at_zero;

  assign cur     = cnt_q & act_mask;
  assign step    = act_mask[0] ? W'(1) : W'(2);
  assign at_top  = (cur == act_mask);
  assign at_zero = (cur == '0);

  always_comb begin
    nxt       = cur;
    reload_ev = 1'b0;
    if (up) begin
      if (at_top) begin
        nxt       = '0;
        reload_ev = 1'b1;
      end else begin
        nxt = (cur + step) & act_mask;
      end
    end else begin
      if (at_zero) begin
        nxt       = load_val & act_mask;
        reload_ev = 1'b1;
      end else begin
        nxt = (cur - step) & act_mask;
      end
    end
  end

  assign step_ev = tick && !load;
  assign zero_ev = step_ev && (nxt == '0) && (up || !reload_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load)    cnt_q <= load_val & act_mask;
    else if (tick)    cnt_q <= nxt;
  end

  assign count = cur;
endmodule

// File: rtl/updn_tmr_cmp_pwm.sv
module updn_tmr_cmp_pwm #(
  parameter int W = updn_tmr_pkg::TMR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_ev,
  input  logic         reload_ev,
  input  logic         zero_ev,
  input  logic [W-1:0] nxt,
  input  logic [W-1:0] cmp_val,
  input  logic [W-1:0] cmp_mask,
  input  logic         pwm_en,
  output logic         irq_cmp,
  output logic         irq_zero,
  output logic         pwm_out
);
  logic match;
  logic cmp_is_zero;
  logic pwm_q;

  assign cmp_is_zero = ((cmp_val & cmp_mask) == '0);
  assign match       = step_ev && (((nxt ^ cmp_val) & cmp_mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_cmp  <= 1'b0;
      irq_zero <= 1'b0;
      pwm_q    <= 1'b0;
    end else begin
      irq_cmp  <= match;
      irq_zero <= zero_ev;
      if (match || cmp_is_zero)       pwm_q <= 1'b0;
      else if (step_ev && reload_ev)  pwm_q <= 1'b1;
    end
  end

  assign pwm_out = pwm_q && pwm_en;
endmodule

// File: rtl/updn_pwm_timer.sv
module updn_pwm_timer
  import updn_tmr_pkg::*;
#(
  parameter int W    = TMR_W,
  parameter int NSRC = TMR_SRC,
  localparam int SEL_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             count_up,
  input  logic [1:0]       len_sel,
  input  logic             skip_lsb,
  input  logic             cmp_full,
  input  logic [W-1:0]     load_val,
  input  logic             load_stb,
  input  logic [W-1:0]     cmp_val,
  input  logic             pwm_en,
  output logic [W-1:0]     count,
  output logic             irq_cmp,
  output logic             irq_zero,
  output logic             pwm_out
);
  logic [W-1:0] width_mask;
  logic [W-1:0] lsb_keep;
  logic [W-1:0] act_mask;
  logic [W-1:0] cmp_mask;
  logic [W-1:0] nxt;
  logic         tick;
  logic         step_ev;
  logic         reload_ev;
  logic         zero_ev;

  assign width_mask = {W{1'b1}} >> (2 * int'(len_sel));
  assign lsb_keep   = ~{{(W-1){1'b0}}, skip_lsb};
  assign act_mask   = width_mask & lsb_keep;
  assign cmp_mask   = (cmp_full ? {W{1'b1}} : width_mask) & lsb_keep;

  updn_tmr_tick_sel #(.NSRC(NSRC)) u_sel (
    .run      (run),
    .src_tick (src_tick),
    .src_sel  (src_sel),
    .tick     (tick)
  );

  updn_tmr_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load      (load_stb),
    .up        (count_up),
    .act_mask  (act_mask),
    .load_val  (load_val),
    .count     (count),
    .nxt       (nxt),
    .step_ev   (step_ev),
    .reload_ev (reload_ev),
    .zero_ev   (zero_ev)
  );

  updn_tmr_cmp_pwm #(.W(W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_ev   (step_ev),
    .reload_ev (reload_ev),
    .zero_ev   (zero_ev),
    .nxt       (nxt),
    .cmp_val   (cmp_val),
    .cmp_mask  (cmp_mask),
    .pwm_en    (pwm_en),
    .irq_cmp   (irq_cmp),
    .irq_zero  (irq_zero),
    .pwm_out   (pwm_out)
  );
endmodule

// File: rtl/updn_pwm_timer_chk.sv
module updn_pwm_timer_chk #(
  parameter int W    = 10,
  parameter int NSRC = 8,
  localparam int SEL_W = $clog2(NSRC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic [NSRC-1:0]  src_tick,
  input logic [SEL_W-1:0] src_sel,
  input logic [1:0]       len_sel,
  input logic             skip_lsb,
  input logic [W-1:0]     load_val,
  input logic             load_stb,
  input logic [W-1:0]     count,
  input logic             irq_cmp,
  input logic             irq_zero,
  input logic             pwm_out
);
  logic         tk;
  logic [W-1:0] msk;

  assign tk  = run && src_tick[src_sel];
  assign msk = ({W{1'b1}} >> (2 * int'(len_sel))) & ~{{(W-1){1'b0}}, skip_lsb};

  a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (count == ($past(load_val) & $past(msk) & msk)));

  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_stb && !tk) |=> ((count == $past(count)) || (len_sel != $past(len_sel))
                            || (skip_lsb != $past(skip_lsb))));

  a_r8_zero_shows_zero: assert property (@(posedge clk) disable iff (!rst_n)
    irq_zero |-> (count == '0));

  a_r8_zero_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_zero) |-> ($past(tk) && !$past(load_stb)));

  a_r9_cmp_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_cmp) |-> ($past(tk) && !$past(load_stb)));

  a_r10_match_drops_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmp |-> !pwm_out);
endmodule

bind updn_pwm_timer updn_pwm_timer_chk #(.W(W), .NSRC(NSRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .src_tick (src_tick),
  .src_sel  (src_sel),
  .len_sel  (len_sel),
  .skip_lsb (skip_lsb),
  .load_val (load_val),
  .load_stb (load_stb),
  .count    (count),
  .irq_cmp  (irq_cmp),
  .irq_zero (irq_zero),
  .pwm_out  (pwm_out)
);

// File: tb/tb_updn_pwm_timer.sv
module tb_updn_pwm_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b1;
  logic [7:0] src_tick = 8'h00;
  logic [2:0] src_sel = 3'd3;
  logic       count_up = 1'b1;
  logic [1:0] len_sel = 2'd0;
  logic       skip_lsb = 1'b0;
  logic       cmp_full = 1'b0;
  logic [9:0] load_val = '0;
  logic       load_stb = 1'b0;
  logic [9:0] cmp_val = '0;
  logic       pwm_en = 1'b1;
  logic [9:0] count;
  logic       irq_cmp, irq_zero, pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  updn_pwm_timer dut (
    .clk(clk), .rst_n(rst_n), .run(run), .src_tick(src_tick), .src_sel(src_sel),
    .count_up(count_up), .len_sel(len_sel), .skip_lsb(skip_lsb), .cmp_full(cmp_full),
    .load_val(load_val), .load_stb(load_stb), .cmp_val(cmp_val), .pwm_en(pwm_en),
    .count(count), .irq_cmp(irq_cmp), .irq_zero(irq_zero), .pwm_out(pwm_out)
  );

  typedef struct packed {
    logic       ld, tk, up;
    logic [1:0] len;
    logic       dc, full;
    logic [9:0] lv, cv, ec;
    logic       ez, ei, ep;
  } vec_t;

  // ld tk up len dc full lv cv | count irq_zero irq_cmp pwm
  localparam vec_t VEC [21] = '{
    '{1,0,1,3,0,0,  14,     5,  14,0,0,0},  // R4 R1 load 4-bit
    '{0,1,1,3,0,0,  14,     5,  15,0,0,0},  // R2 increment
    '{0,1,1,3,0,0,  14,     5,   0,1,0,1},  // R2 R8 R10 wrap
    '{0,1,1,3,0,0,  14,     5,   1,0,0,1},  // R2
    '{1,0,1,3,0,0,   4,     5,   4,0,0,1},  // R4
    '{0,1,1,3,0,0,   4,     5,   5,0,1,0},  // R9 R10 match
    '{1,0,0,3,0,0,   2,     5,   2,0,0,0},  // R4
    '{0,1,0,3,0,0,   2,     5,   1,0,0,0},  // R3 decrement
    '{0,1,0,3,0,0,   2,     5,   0,1,0,0},  // R3 R8 reach zero
    '{0,1,0,3,0,0,   2,     5,   2,0,0,1},  // R3 R10 reload
    '{0,0,0,3,0,0,   2,     5,   2,0,0,1},  // R5 unselected sources high
    '{1,0,1,2,1,0,   7,    10,   6,0,0,1},  // R7 R1 masked load
    '{0,1,1,2,1,0,   7,    10,   8,0,0,1},  // R7 step 2
    '{0,1,1,2,1,0,   7,    10,  10,0,1,0},  // R7 R9 match
    '{1,0,0,1,0,1,   6,10'h105,  6,0,0,0},  // R4 8-bit
    '{0,1,0,1,0,1,   6,10'h105,  5,0,0,0},  // R6 full compare no match
    '{1,0,0,1,0,0,   6,10'h105,  6,0,0,0},  // R4
    '{0,1,0,1,0,0,   6,10'h105,  5,0,1,0},  // R6 limited compare match
    '{1,0,1,0,0,0,1023,10'h105,1023,0,0,0}, // R1 full width load
    '{0,1,1,0,0,0,1023,10'h105,  0,1,0,1},  // R2 R8 10-bit wrap
    '{0,1,1,0,0,0,1023,10'h105,  1,0,0,1}   // R2
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic ld, input logic tk);
    @(negedge clk);
    load_stb = ld;
    src_tick = tk ? 8'hFF : 8'hF7;
    @(posedge clk);
    @(negedge clk);
    load_stb = 1'b0;
    src_tick = 8'hF7;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 R8 R9 R10: reset state
    chk(count == 0, "R1 reset count", count, 0);
    chk({irq_cmp, irq_zero, pwm_out} == 3'b000, "R10 reset outputs",
        {irq_cmp, irq_zero, pwm_out}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 21; i++) begin
      @(negedge clk);
      count_up = VEC[i].up; len_sel = VEC[i].len; skip_lsb = VEC[i].dc;
      cmp_full = VEC[i].full; load_val = VEC[i].lv; cmp_val = VEC[i].cv;
      drive(VEC[i].ld, VEC[i].tk);
      chk(count == VEC[i].ec, $sformatf("vec%0d count (R1-table)", i), count, VEC[i].ec);
      chk(irq_zero == VEC[i].ez, $sformatf("vec%0d R8 irq_zero", i), irq_zero, VEC[i].ez);
      chk(irq_cmp == VEC[i].ei, $sformatf("vec%0d R9 irq_cmp", i), irq_cmp, VEC[i].ei);
      chk(pwm_out == VEC[i].ep, $sformatf("vec%0d R10 pwm", i), pwm_out, VEC[i].ep);
    end

    // R4: load beats tick
    count_up = 1'b1; len_sel = 2'd0; skip_lsb = 1'b0; load_val = 10'd9; cmp_val = 10'd100;
    drive(1'b1, 1'b1);
    chk(count == 9, "R4 load priority", count, 9);
    chk(irq_zero == 0 && irq_cmp == 0, "R4 no irq on load", {irq_zero, irq_cmp}, 0);

    // R5: run low blocks the selected source
    run = 1'b0;
    drive(1'b0, 1'b1);
    chk(count == 9, "R5 run low", count, 9);
    run = 1'b1;
    drive(1'b0, 1'b1);
    chk(count == 10, "R5 run high", count, 10);

    // R10: compare 0 keeps pwm low through a wrap
    len_sel = 2'd3; load_val = 10'd14; cmp_val = 10'd0;
    drive(1'b1, 1'b0);
    chk(pwm_out == 0, "R10 cmp0 after load", pwm_out, 0);
    drive(1'b0, 1'b1);
    chk(count == 15 && pwm_out == 0, "R10 cmp0 at top", pwm_out, 0);
    drive(1'b0, 1'b1);
    chk(count == 0 && irq_zero && irq_cmp, "R9 cmp0 match on wrap", {irq_zero, irq_cmp}, 3);
    chk(pwm_out == 0, "R10 cmp0 wrap", pwm_out, 0);

    // R10: pwm_en gating
    cmp_val = 10'd5; load_val = 10'd15; pwm_en = 1'b0;
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b1);
    chk(pwm_out == 0, "R10 gated", pwm_out, 0);
    pwm_en = 1'b1;
    #1;
    chk(pwm_out == 1, "R10 ungated", pwm_out, 1);

    // R1 R2: 6-bit wrap without lsb skip
    len_sel = 2'd2; load_val = 10'd63;
    drive(1'b1, 1'b0);
    chk(count == 63, "R1 6-bit top", count, 63);
    drive(1'b0, 1'b1);
    chk(count == 0 && irq_zero == 1, "R2 6-bit wrap", count, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule